// File: doc/BRIEF.md
# Complex Lag Correlator Section

This block is one section of a complex-lag cross-correlator. Two streams of signed 4-bit samples, X and Y, arrive together with a 4-bit phase word and a valid strobe. The X sample and its phase word travel down a lag delay line that advances only on valid samples. At every lag, the delayed X sample is multiplied by the current Y sample at full precision. The product is rotated by a coarse three-level rotator, driven by the phase word carried with that X sample, into an in-phase part and a quadrature part. Each part is added to its own wide accumulator, and nothing is truncated.

A dump command ends an integration. In that cycle every lag's I and Q totals are copied into an output bank. The accumulators then restart from the contribution of the sample present in the dump cycle, so no sample is lost between integrations. A done pulse reports that the bank is updated. The bank is read through an indexed port with one cycle of latency, without any processor taking part. The lag count is a parameter (default 128). Chaining of sections, clocking and serial links are handled outside this block.

Top module: `lag_corr_section`

## Requirements
- R1: While reset is high, and in the first cycle after it, done_o is 0 and rd_data_o is 0 for any index. All accumulators, bank entries and delay taps start at zero.
- R2: Lag k pairs the current Y sample with the X sample (and its phase word) received k valid samples earlier; lag 0 uses the current X. Taps that have not yet been filled since reset hold zero.
- R3: The product at each lag is the exact signed product of two two's-complement 4-bit samples, including (-8)x(-8)=+64.
- R4: The phase word p selects the angle 2πp/16. The I accumulator adds product x c, where c is +1 if cos > 0.38, -1 if cos < -0.38, and 0 otherwise. This gives c=+1 for p in {13,14,15,0,1,2,3}, 0 for p in {4,12}, and -1 for p in {5..11}.
- R5: The Q accumulator adds product x (-s), where s is the sine coefficient under the same thresholds: s=0 for p in {0,8}, +1 for p in {1..7}, and -1 for p in {9..15}.
- R6: A sample with valid_i low changes no accumulator and does not advance the delay line.
- R7: When dump_i is high, the bank takes every lag's totals as they stood before this cycle. Each accumulator is reloaded with this cycle's contribution: zero if valid_i is low, otherwise that sample's rotated product.
- R8: done_o is high in exactly the cycle after each cycle with dump_i high.
- R9: rd_data_o shows, one cycle after rd_lag_i is presented, {I[22:0], Q[22:0]} of bank entry rd_lag_i, with I in the upper half. Any index of LAGS or above reads as 0. A read in a dump cycle returns the bank contents from before the dump.
- R10: The bank keeps its contents unchanged between dumps, whatever samples stream in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Qualifies the sample pair and phase word |
| x_i | input | 4 | Signed X sample, fed to the lag delay line |
| y_i | input | 4 | Signed Y sample, common to all lags |
| phase_i | input | 4 | Phase word carried with the X sample |
| dump_i | input | 1 | Ends the integration and updates the bank |
| done_o | output | 1 | Pulse one cycle after a dump |
| rd_lag_i | input | clog2(LAGS)+1 | Lag index to read |
| rd_data_o | output | 2*ACC_W | Registered {I, Q} of the selected lag |

## Verification
Assertions check on every cycle the following: that idle cycles leave the delay taps and the accumulators untouched, that a dump without a valid sample clears the accumulators, that a zero rotator coefficient freezes the matching accumulator, that the bank stays stable outside dumps, the done timing, and that an out-of-range read returns zero. The bench's reference model must do the rest. It compares the rotator tables computed from real cosine and sine values, the exact products at the extreme codes, the lag alignment after gaps in the valid strobe, and the dump boundary that splits a live sample stream. It compares every clock against the read port and done flag.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int PH_W = 4;

  typedef logic signed [1:0] coef_t;

  // three-level sine of 2*pi*p/16 with a 0.38 dead zone
  function automatic coef_t sin_coef(input logic [PH_W-1:0] p);
    if (p == 4'd0 || p == 4'd8) return 2'sb00;
    else if (p < 4'd8)          return 2'sb01;
    else                        return 2'sb11;
  endfunction

  // cosine is the sine a quarter turn ahead
  function automatic coef_t cos_coef(input logic [PH_W-1:0] p);
    return sin_coef(p + 4'd4);
  endfunction
endpackage

// File: rtl/lc_delay_line.sv
module lc_delay_line
  import lc_pkg::*;
#(
  parameter int LAGS   = 128,
  parameter int SAMP_W = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             valid_i,
  input  logic [SAMP_W-1:0]                x_i,
  input  logic [PH_W-1:0]                  ph_i,
  output logic [LAGS-1:0][SAMP_W-1:0]      tap_x_o,
  output logic [LAGS-1:0][PH_W-1:0]        tap_ph_o
);
  localparam int SR_D = LAGS - 1;

  logic [SR_D-1:0][SAMP_W-1:0] sr_x;
  logic [SR_D-1:0][PH_W-1:0]   sr_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_x  <= '0;
      sr_ph <= '0;
    end else if (valid_i) begin
      sr_x[0]  <= x_i;
      sr_ph[0] <= ph_i;
      for (int i = 1; i < SR_D; i++) begin
        sr_x[i]  <= sr_x[i-1];
        sr_ph[i] <= sr_ph[i-1];
      end
    end
  end

  for (genvar k = 0; k < LAGS; k++) begin : g_tap
    if (k == 0) begin : g_live
      assign tap_x_o[k]  = x_i;
      assign tap_ph_o[k] = ph_i;
    end else begin : g_reg
      assign tap_x_o[k]  = sr_x[k-1];
      assign tap_ph_o[k] = sr_ph[k-1];
    end
  end

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(sr_x) && $stable(sr_ph))); // R6
endmodule

// File: rtl/lc_lag_cell.sv
module lc_lag_cell
  import lc_pkg::*;
#(
  parameter int SAMP_W = 4,
  parameter int ACC_W  = 23
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid_i,
  input  logic                     dump_i,
  input  logic signed [SAMP_W-1:0] x_i,
  input  logic signed [SAMP_W-1:0] y_i,
  input  logic [PH_W-1:0]          ph_i,
  output logic signed [ACC_W-1:0]  acc_i_o,
  output logic signed [ACC_W-1:0]  acc_q_o
);
  localparam int PROD_W = 2 * SAMP_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  term_i, term_q;
  coef_t                    c_cos, c_sin;

  assign prod     = x_i * y_i;
  assign prod_ext = ACC_W'(prod);
  assign c_cos    = cos_coef(ph_i);
  assign c_sin    = sin_coef(ph_i);

  always_comb begin
    term_i = '0;
    term_q = '0;
    if (valid_i) begin
      if (c_cos == 2'sb01)      term_i = prod_ext;
      else if (c_cos == 2'sb11) term_i = -prod_ext;
      if (c_sin == 2'sb01)      term_q = -prod_ext;
      else if (c_sin == 2'sb11) term_q = prod_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_i_o <= '0;
      acc_q_o <= '0;
    end else if (dump_i) begin
      acc_i_o <= term_i;
      acc_q_o <= term_q;
    end else begin
      acc_i_o <= acc_i_o + term_i;
      acc_q_o <= acc_q_o + term_q;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!valid_i && !dump_i) |=> ($stable(acc_i_o) && $stable(acc_q_o))); // R6
  AST_DUMP_RESTART: assert property (@(posedge clk) disable iff (rst)
    (dump_i && !valid_i) |=> (acc_i_o == '0 && acc_q_o == '0)); // R7
  AST_COS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!dump_i && (ph_i == 4'd4 || ph_i == 4'd12)) |=> $stable(acc_i_o)); // R4
  AST_SIN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!dump_i && (ph_i == 4'd0 || ph_i == 4'd8)) |=> $stable(acc_q_o)); // R5
endmodule

// File: rtl/lc_readout.sv
module lc_readout #(
  parameter int LAGS  = 128,
  parameter int ACC_W = 23,
  parameter int RD_W  = $clog2(LAGS) + 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           dump_i,
  input  logic [LAGS-1:0][2*ACC_W-1:0]   acc_bus_i,
  input  logic [RD_W-1:0]                rd_lag_i,
  output logic [2*ACC_W-1:0]             rd_data_o,
  output logic                           done_o
);
  localparam int IDX_W = $clog2(LAGS);

  logic [LAGS-1:0][2*ACC_W-1:0] bank;
  logic                         in_range;

  assign in_range = (rd_lag_i < RD_W'(LAGS));

  always_ff @(posedge clk) begin
    if (rst) begin
      bank      <= '0;
      rd_data_o <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o    <= dump_i;
      if (dump_i) bank <= acc_bus_i;
      rd_data_o <= in_range ? bank[rd_lag_i[IDX_W-1:0]] : '0;
    end
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dump_i |=> $stable(bank)); // R10
  AST_DONE_AFTER_DUMP: assert property (@(posedge clk) disable iff (rst)
    dump_i |=> done_o); // R8
  AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_lag_i >= RD_W'(LAGS)) |=> (rd_data_o == '0)); // R9
endmodule

// File: rtl/lag_corr_section.sv
module lag_corr_section
  import lc_pkg::*;
#(
  parameter int LAGS     = 128,
  parameter int SAMP_W   = 4,
  parameter int ACC_W    = 23,
  localparam int RD_W    = $clog2(LAGS) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_i,
  input  logic [SAMP_W-1:0]   x_i,
  input  logic [SAMP_W-1:0]   y_i,
  input  logic [PH_W-1:0]     phase_i,
  input  logic                dump_i,
  output logic                done_o,
  input  logic [RD_W-1:0]     rd_lag_i,
  output logic [2*ACC_W-1:0]  rd_data_o
);
  logic [LAGS-1:0][SAMP_W-1:0]  tap_x;
  logic [LAGS-1:0][PH_W-1:0]    tap_ph;
  logic [LAGS-1:0][2*ACC_W-1:0] acc_bus;

  lc_delay_line #(.LAGS(LAGS), .SAMP_W(SAMP_W)) u_dline (
    .clk      (clk),
    .rst      (rst),
    .valid_i  (valid_i),
    .x_i      (x_i),
    .ph_i     (phase_i),
    .tap_x_o  (tap_x),
    .tap_ph_o (tap_ph)
  );

  for (genvar k = 0; k < LAGS; k++) begin : g_lag
    logic signed [ACC_W-1:0] acc_i, acc_q;

    lc_lag_cell #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .valid_i (valid_i),
      .dump_i  (dump_i),
      .x_i     ($signed(tap_x[k])),
      .y_i     ($signed(y_i)),
      .ph_i    (tap_ph[k]),
      .acc_i_o (acc_i),
      .acc_q_o (acc_q)
    );

    assign acc_bus[k] = {acc_i, acc_q};
  end

  lc_readout #(.LAGS(LAGS), .ACC_W(ACC_W), .RD_W(RD_W)) u_rdout (
    .clk       (clk),
    .rst       (rst),
    .dump_i    (dump_i),
    .acc_bus_i (acc_bus),
    .rd_lag_i  (rd_lag_i),
    .rd_data_o (rd_data_o),
    .done_o    (done_o)
  );
endmodule

// File: tb/lag_corr_section_tb_top.sv
`timescale 1ns/1ps
module lag_corr_section_tb_top;
  localparam int LAGS = 8;
  localparam int AW   = 23;
  localparam int RW   = $clog2(LAGS) + 1;
  localparam int DW   = 2 * AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_i = 1'b0;
  logic [3:0]    x_i = '0, y_i = '0, phase_i = '0;
  logic          dump_i = 1'b0;
  logic [RW-1:0] rd_lag_i = '0;
  logic          done_o;
  logic [DW-1:0] rd_data_o;

  lag_corr_section #(.LAGS(LAGS), .SAMP_W(4), .ACC_W(AW)) dut_i (
    .clk(clk), .rst(rst), .valid_i(valid_i), .x_i(x_i), .y_i(y_i),
    .phase_i(phase_i), .dump_i(dump_i), .done_o(done_o),
    .rd_lag_i(rd_lag_i), .rd_data_o(rd_data_o)
  );

  always #2.5 clk = ~clk;

  int    n_checks = 0, n_errors = 0;
  bit    checking = 0, finished = 0;
  string cur_req = "R1";

  // reference model state
  int            acc_mi[LAGS], acc_mq[LAGS], bank_mi[LAGS], bank_mq[LAGS];
  int            hx[$], hp[$];
  logic          exp_done = 1'b0;
  logic [DW-1:0] exp_rd = '0;

  function automatic int level(real v);
    if (v > 0.38) return 1;
    if (v < -0.38) return -1;
    return 0;
  endfunction

  function automatic int cosc(int p);
    return level($cos(2.0 * 3.14159265358979 * p / 16.0));
  endfunction

  function automatic int sinc(int p);
    return level($sin(2.0 * 3.14159265358979 * p / 16.0));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LAGS; k++) begin
        acc_mi[k] = 0; acc_mq[k] = 0; bank_mi[k] = 0; bank_mq[k] = 0;
      end
      hx.delete(); hp.delete();
      exp_done = 1'b0;
      exp_rd   = '0;
    end else begin
      int xs0, ys, p0;
      xs0 = $signed(x_i);
      ys  = $signed(y_i);
      p0  = int'(phase_i);
      if (int'(rd_lag_i) < LAGS) begin
        logic [31:0] ti, tq;
        ti = bank_mi[rd_lag_i];
        tq = bank_mq[rd_lag_i];
        exp_rd = {ti[AW-1:0], tq[AW-1:0]};
      end else begin
        exp_rd = '0;
      end
      for (int k = 0; k < LAGS; k++) begin
        int xs, ps, pr, ci, cq;
        if (k == 0) begin xs = xs0; ps = p0; end
        else if (k - 1 < hx.size()) begin xs = hx[k-1]; ps = hp[k-1]; end
        else begin xs = 0; ps = 0; end
        pr = xs * ys;
        ci = valid_i ? pr * cosc(ps) : 0;
        cq = valid_i ? -pr * sinc(ps) : 0;
        if (dump_i) begin
          bank_mi[k] = acc_mi[k]; bank_mq[k] = acc_mq[k];
          acc_mi[k] = ci; acc_mq[k] = cq;
        end else begin
          acc_mi[k] += ci; acc_mq[k] += cq;
        end
      end
      exp_done = dump_i;
      if (valid_i) begin
        hx.push_front(xs0); hp.push_front(p0);
        if (hx.size() > LAGS) begin void'(hx.pop_back()); void'(hp.pop_back()); end
      end
    end
  end

  always @(negedge clk) begin
    if (checking && !finished) begin
      n_checks++;
      if (done_o !== exp_done) begin
        n_errors++;
        $display("FAIL %s: done_o got %b expected %b", cur_req, done_o, exp_done);
      end
      n_checks++;
      if (rd_data_o !== exp_rd) begin
        n_errors++;
        $display("FAIL %s: rd_data_o got %h expected %h", cur_req, rd_data_o, exp_rd);
      end
    end
  end

  task automatic drive(input bit v, input int x, input int y, input int p, input bit d,
                       input int lag);
    @(negedge clk);
    valid_i  = v;
    x_i      = 4'(x);
    y_i      = 4'(y);
    phase_i  = 4'(p);
    dump_i   = d;
    rd_lag_i = RW'(lag);
  endtask

  task automatic read_all();
    for (int i = 0; i < 2 * LAGS; i++) drive(0, 0, 0, 0, 0, i);
    drive(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: got hung run expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed));
    // R1: reset state
    cur_req = "R1";
    @(posedge clk);
    #1 checking = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    read_all();

    // R3: extreme codes, exact product
    cur_req = "R3";
    for (int i = 0; i < 10; i++) drive(1, -8, -8, 0, 0, 0);
    for (int i = 0; i < 5; i++) drive(1, 7, -8, 1, 0, 1);
    drive(0, 0, 0, 0, 1, 0);
    read_all();

    // R2: impulse on X shows lag alignment, gaps in valid included
    cur_req = "R2";
    drive(1, 3, 1, 2, 1, 0);
    for (int i = 0; i < LAGS + 2; i++) begin
      drive(1, 0, i + 1, 0, 0, i % LAGS);
      drive(0, 5, 5, 3, 0, 0);
    end
    drive(0, 0, 0, 0, 1, 0);
    read_all();

    // R4 R5: every phase word through both rotator tables
    cur_req = "R4 R5";
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < LAGS + 1; i++) drive(1, i % 7 - 3, 5, p, 0, 0);
      drive(1, 2, -3, p, 1, 0);
      read_all();
    end

    // R6: random stream with valid low on many cycles
    cur_req = "R6";
    for (int i = 0; i < 400; i++)
      drive($urandom_range(0, 9) < 4, $urandom_range(0, 15), $urandom_range(0, 15),
            $urandom_range(0, 15), 1'b0, $urandom_range(0, 2 * LAGS - 1));
    drive(0, 0, 0, 0, 1, 0);
    read_all();

    // R7: dump with live sample, back-to-back dumps, dump while idle
    cur_req = "R7";
    for (int i = 0; i < 20; i++) drive(1, $urandom_range(0, 15), $urandom_range(0, 15),
                                      $urandom_range(0, 15), 0, 0);
    drive(1, -8, 7, 14, 1, 0);
    drive(1, 6, -5, 9, 1, 0);
    drive(0, 1, 1, 0, 1, 0);
    read_all();
    drive(0, 0, 0, 0, 1, 0);
    read_all();

    // R8: spaced dumps, done pulse timing
    cur_req = "R8";
    for (int j = 0; j < 6; j++) begin
      for (int i = 0; i < j; i++) drive(1, 1, 1, 0, 0, 0);
      drive(j % 2 == 0, 2, 2, 0, 1, 0);
    end
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);

    // R9: out-of-range and in-range reads, read during a dump
    cur_req = "R9";
    for (int i = 0; i < 10; i++) drive(1, 4, -4, 15, 0, 0);
    drive(1, 3, 3, 0, 1, LAGS - 1);
    drive(0, 0, 0, 0, 0, LAGS);
    drive(0, 0, 0, 0, 0, 2 * LAGS - 1);
    drive(0, 0, 0, 0, 0, LAGS + 1);
    read_all();

    // R10: bank unchanged while a new integration streams in
    cur_req = "R10";
    for (int i = 0; i < 6 * LAGS; i++)
      drive(1, $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
            0, i % LAGS);
    drive(0, 0, 0, 0, 1, 0);
    read_all();

    drive(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    finish_run();
  end
endmodule